// File: doc/BRIEF.md
# PC Platform Reset Controller

This block collects every reset request of a legacy PC-style platform and turns them into two separate processor reset lines. The hard reset returns the whole platform to its power-up state. The soft reset (INIT) reinitialises the processor only. Each request source is routed to exactly one of the two lines; requests are not OR-ed onto a single reset.

The hard line has two sources: power-good rising (held off until 1 ms of stable power, counted on the reference clock) and a resume-from-suspend wake request. A third way to reach it is a software request through the reset-control port. The INIT line has four sources: a processor shutdown cycle (for example after a triple fault), a keyboard-controller request, the fast-reset port, and the reset-control port.

Every triggered pulse is stretched to a fixed minimum width. A one-hot cause register remembers which source started the latest pulse. The block also mirrors a processor identifier and an arbitration identifier. INIT leaves both untouched and any hard reset clears them.

Top module: `sys_reset_ctrl`

## Requirements
- R1: While `pwr_good` is low, `hard_rst` is 1 and `init_rst` is 0. After `pwr_good` rises, `hard_rst` falls on the CLK_KHZ-th rising clock edge, which is 1 ms of reference clock.
- R2: A one-cycle `wake_req`, or an I/O write to address 0x93 whose data has bit 1 = 1 and sets bit 2 from 0 to 1, starts a `hard_rst` pulse on the next edge. The pulse lasts exactly MIN_PULSE cycles, and `init_rst` stays 0.
- R3: Each of these starts an `init_rst` pulse of exactly MIN_PULSE cycles on the next edge, with `hard_rst` staying 0: `cpu_shutdown`, `kbc_rst_req`, a write to 0x92 with data bit 0 = 1, and a write to 0x93 with bit 1 = 0 that sets bit 2 from 0 to 1.
- R4: A write to 0x92 with data bit 0 = 0 causes no reset. A write to 0x93 while its stored bit 2 is already 1 causes no reset.
- R5: A request that arrives while its output is already asserted is merged into that pulse. The pulse keeps its original end and the cause register is unchanged.
- R6: `hard_rst` and `init_rst` are never 1 together. If hard and soft requests arrive in the same cycle, only `hard_rst` pulses. A hard start ends a running INIT pulse on the same edge.
- R7: `proc_id` and `arb_id` keep their value through an INIT pulse, and read 0 after any hard reset.
- R8: `rst_cause` is one-hot with these bit positions: 0 power-on, 1 wake, 2 control-port hard, 3 shutdown, 4 keyboard, 5 fast port, 6 control-port soft. It reads 7'b0000001 after power-up and is updated only when a pulse starts.
- R9: Reading address 0x92 returns bit 0 = 1 while the INIT pulse that a fast-port write started is running, and 0 once that pulse has ended.
- R10: Reading 0x93 returns the stored bits 2:1. A hard reset clears them. I/O and identifier writes made while `hard_rst` is 1 are ignored.
- R11: When several sources of the same kind request in the same cycle, `rst_cause` records the one with the lowest bit index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| pwr_good | input | 1 | Power good; low holds everything in power-on reset |
| wake_req | input | 1 | Resume-from-suspend request (hard) |
| cpu_shutdown | input | 1 | Processor shutdown-cycle indication (soft) |
| kbc_rst_req | input | 1 | Keyboard-controller reset request (soft) |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | ADDR_W | I/O address for write and read |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | Read data for `io_addr` (combinational) |
| id_wr | input | 1 | Load both identifier mirrors |
| id_proc_wdata | input | ID_W | New processor identifier |
| id_arb_wdata | input | ID_W | New arbitration identifier |
| proc_id | output | ID_W | Processor identifier mirror |
| arb_id | output | ID_W | Arbitration identifier mirror |
| hard_rst | output | 1 | Hard reset, active high |
| init_rst | output | 1 | Soft reset (INIT), active high |
| rst_cause | output | 7 | One-hot source of the latest reset |

## Verification
Each source is fired on its own so that the output line it drives, the pulse width and the cause bit can all be checked. This tells the hard set apart from the soft set. Pairs of requests are then fired together or staggered. Same-cycle hard and soft requests show priority, a soft request during INIT shows merging, a wake during INIT shows preemption, and two soft requests together show the cause ordering. Writes that must not trigger (0x92 with bit 0 clear, 0x93 with bit 2 already set, anything during a hard pulse) are then read back through the ports. A seeded random sequence of sources with changing identifier values closes the run and checks which mirrors survive each kind of reset.

// File: rtl/rst_ctrl_pkg.sv
package rst_ctrl_pkg;

    localparam int NUM_CAUSE = 7;

    typedef enum logic [2:0] {
        C_POR      = 3'd0,
        C_WAKE     = 3'd1,
        C_CTL_HARD = 3'd2,
        C_SHUTDOWN = 3'd3,
        C_KBC      = 3'd4,
        C_FAST     = 3'd5,
        C_CTL_SOFT = 3'd6
    } cause_e;

    typedef logic [NUM_CAUSE-1:0] cause_vec_t;

    // isolate the lowest set bit: lowest index wins
    function automatic cause_vec_t first_set(cause_vec_t v);
        return v & (~v + cause_vec_t'(1));
    endfunction

endpackage

// File: rtl/rst_pwrup_timer.sv
module rst_pwrup_timer #(
    parameter int LIMIT = 100000
) (
    input  logic clk,
    input  logic rst_n,
    output logic busy_o
);
    localparam int CW = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != CW'(LIMIT)) st_d.cnt = st_q.cnt + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = (st_q.cnt != CW'(LIMIT));

    // once released, the power-up hold never returns without power-good loss
    p_pwrup_once_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> !busy_o);

endmodule

// File: rtl/rst_stretch.sv
module rst_stretch #(
    parameter int MIN_PULSE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic blk_i,
    input  logic clr_i,
    output logic active_o,
    output logic start_o,
    output logic last_o
);
    localparam int CW = $clog2(MIN_PULSE + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } str_t;

    str_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        start_o = req_i && !blk_i && (st_q.cnt == '0);
        if (clr_i)                st_d.cnt = '0;
        else if (start_o)         st_d.cnt = CW'(MIN_PULSE);
        else if (st_q.cnt != '0)  st_d.cnt = st_q.cnt - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_o = (st_q.cnt != '0);
    assign last_o   = (st_q.cnt == CW'(1));

    // checker: count active cycles, verify full width when not cut short
    logic [CW:0] wid_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         wid_q <= '0;
        else if (!active_o) wid_q <= '0;
        else                wid_q <= wid_q + (CW+1)'(1);
    end

    p_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(active_o) && !$past(clr_i)) |-> (wid_q == (CW+1)'(MIN_PULSE)));

    p_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o && !clr_i) |=> active_o);

endmodule

// File: rtl/rst_io_regs.sv
module rst_io_regs #(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] FAST_ADDR = 16'h0092,
    parameter logic [15:0] CTL_ADDR  = 16'h0093,
    parameter int          ID_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic              id_wr,
    input  logic [ID_W-1:0]   id_proc_wdata,
    input  logic [ID_W-1:0]   id_arb_wdata,
    input  logic              hard_active_i,
    input  logic              hard_clr_i,
    input  logic              init_active_i,
    input  logic              init_last_i,
    output logic              fast_req_o,
    output logic              ctl_hard_req_o,
    output logic              ctl_soft_req_o,
    output logic [ID_W-1:0]   proc_id_o,
    output logic [ID_W-1:0]   arb_id_o
);
    typedef struct packed {
        logic            fast;
        logic            ctl_kind;
        logic            ctl_trig;
        logic [ID_W-1:0] pid;
        logic [ID_W-1:0] aid;
    } io_t;

    io_t st_d, st_q;
    logic wr_ok, fast_hit, ctl_hit, ctl_rise;

    always_comb begin
        wr_ok    = io_wr && !hard_active_i;
        fast_hit = wr_ok && (io_addr == ADDR_W'(FAST_ADDR)) && io_wdata[0];
        ctl_hit  = wr_ok && (io_addr == ADDR_W'(CTL_ADDR));
        ctl_rise = ctl_hit && io_wdata[2] && !st_q.ctl_trig;

        fast_req_o     = fast_hit;
        ctl_hard_req_o = ctl_rise && io_wdata[1];
        ctl_soft_req_o = ctl_rise && !io_wdata[1];

        st_d = st_q;
        if (hard_clr_i) begin
            st_d = '0;
        end else begin
            if (ctl_hit) begin
                st_d.ctl_kind = io_wdata[1];
                st_d.ctl_trig = io_wdata[2];
            end
            if (init_last_i)   st_d.fast = 1'b0;
            else if (fast_hit) st_d.fast = 1'b1;
            if (id_wr) begin
                st_d.pid = id_proc_wdata;
                st_d.aid = id_arb_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        io_rdata = '0;
        if (io_addr == ADDR_W'(FAST_ADDR))     io_rdata = {7'b0, st_q.fast};
        else if (io_addr == ADDR_W'(CTL_ADDR)) io_rdata = {5'b0, st_q.ctl_trig, st_q.ctl_kind, 1'b0};
    end

    assign proc_id_o = st_q.pid;
    assign arb_id_o  = st_q.aid;

    p_fast_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fast |-> init_active_i);

    p_ids_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hard_clr_i |=> (proc_id_o == '0 && arb_id_o == '0));

endmodule

// File: rtl/sys_reset_ctrl.sv
module sys_reset_ctrl #(
    parameter int          CLK_KHZ   = 100000,
    parameter int          MIN_PULSE = 16,
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] FAST_ADDR = 16'h0092,
    parameter logic [15:0] CTL_ADDR  = 16'h0093,
    parameter int          ID_W      = 4
) (
    input  logic              clk,
    input  logic              pwr_good,
    input  logic              wake_req,
    input  logic              cpu_shutdown,
    input  logic              kbc_rst_req,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic              id_wr,
    input  logic [ID_W-1:0]   id_proc_wdata,
    input  logic [ID_W-1:0]   id_arb_wdata,
    output logic [ID_W-1:0]   proc_id,
    output logic [ID_W-1:0]   arb_id,
    output logic              hard_rst,
    output logic              init_rst,
    output logic [6:0]        rst_cause
);
    import rst_ctrl_pkg::*;

    localparam int PWRUP_CYC = CLK_KHZ;   // 1 ms of reference clock

    logic rst_n;
    logic pu_busy, hard_cnt_on, hard_start, hard_last, hard_active, hard_clr;
    logic soft_active, soft_start, soft_last;
    logic fast_req, ctl_hard_req, ctl_soft_req;
    cause_vec_t hard_vec, soft_vec;

    assign rst_n = pwr_good;

    rst_pwrup_timer #(.LIMIT(PWRUP_CYC)) u_pwrup (
        .clk(clk), .rst_n(rst_n), .busy_o(pu_busy)
    );

    rst_io_regs #(
        .ADDR_W(ADDR_W), .FAST_ADDR(FAST_ADDR), .CTL_ADDR(CTL_ADDR), .ID_W(ID_W)
    ) u_io (
        .clk(clk), .rst_n(rst_n),
        .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .id_wr(id_wr), .id_proc_wdata(id_proc_wdata), .id_arb_wdata(id_arb_wdata),
        .hard_active_i(hard_active), .hard_clr_i(hard_clr),
        .init_active_i(soft_active), .init_last_i(soft_last),
        .fast_req_o(fast_req), .ctl_hard_req_o(ctl_hard_req), .ctl_soft_req_o(ctl_soft_req),
        .proc_id_o(proc_id), .arb_id_o(arb_id)
    );

    always_comb begin
        hard_vec             = '0;
        hard_vec[C_WAKE]     = wake_req;
        hard_vec[C_CTL_HARD] = ctl_hard_req;
        soft_vec             = '0;
        soft_vec[C_SHUTDOWN] = cpu_shutdown;
        soft_vec[C_KBC]      = kbc_rst_req;
        soft_vec[C_FAST]     = fast_req;
        soft_vec[C_CTL_SOFT] = ctl_soft_req;
    end

    rst_stretch #(.MIN_PULSE(MIN_PULSE)) u_hard (
        .clk(clk), .rst_n(rst_n), .req_i(|hard_vec), .blk_i(pu_busy), .clr_i(1'b0),
        .active_o(hard_cnt_on), .start_o(hard_start), .last_o(hard_last)
    );

    assign hard_active = pu_busy || hard_cnt_on;
    assign hard_clr    = hard_start || hard_active;

    rst_stretch #(.MIN_PULSE(MIN_PULSE)) u_soft (
        .clk(clk), .rst_n(rst_n), .req_i(|soft_vec), .blk_i(hard_clr), .clr_i(hard_clr),
        .active_o(soft_active), .start_o(soft_start), .last_o(soft_last)
    );

    typedef struct packed {
        cause_vec_t cause;
    } top_t;

    top_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hard_start)      st_d.cause = first_set(hard_vec);
        else if (soft_start) st_d.cause = first_set(soft_vec);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cause: cause_vec_t'(1) << C_POR};
        else        st_q <= st_d;
    end

    assign hard_rst  = hard_active;
    assign init_rst  = soft_active;
    assign rst_cause = st_q.cause;

    p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(hard_rst && init_rst));

    p_cause_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rst_cause) == 1);

    p_hard_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hard_start |=> (rst_cause[C_WAKE] || rst_cause[C_CTL_HARD]));

    p_hard_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hard_last && !pu_busy) |=> !hard_rst);

endmodule

// File: tb/sim_sys_reset_ctrl.sv
module sim_sys_reset_ctrl;
    localparam int KHZ  = 40;
    localparam int MINP = 16;
    localparam int IDW  = 4;

    logic clk = 1'b0;
    logic pwr_good = 1'b0, wake_req = 1'b0, cpu_shutdown = 1'b0, kbc_rst_req = 1'b0;
    logic io_wr = 1'b0, id_wr = 1'b0;
    logic [15:0] io_addr = 16'h0;
    logic [7:0]  io_wdata = 8'h0, io_rdata;
    logic [IDW-1:0] id_proc_wdata = '0, id_arb_wdata = '0, proc_id, arb_id;
    logic hard_rst, init_rst;
    logic [6:0] rst_cause;

    int total = 0, bad = 0;
    int unsigned cyc = 0;
    logic [IDW-1:0] exp_pid = '0, exp_aid = '0;

    always #5 clk = ~clk;

    sys_reset_ctrl #(.CLK_KHZ(KHZ), .MIN_PULSE(MINP), .ID_W(IDW)) u0 (
        .clk(clk), .pwr_good(pwr_good), .wake_req(wake_req), .cpu_shutdown(cpu_shutdown),
        .kbc_rst_req(kbc_rst_req), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .id_wr(id_wr), .id_proc_wdata(id_proc_wdata),
        .id_arb_wdata(id_arb_wdata), .proc_id(proc_id), .arb_id(arb_id),
        .hard_rst(hard_rst), .init_rst(init_rst), .rst_cause(rst_cause)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit is_hard(input int src);
        return (src == 1) || (src == 2);
    endfunction

    function automatic int exp_cause(input int src);
        return 1 << src;
    endfunction

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic fire(input int src);
        case (src)
            1: begin wake_req = 1'b1; @(negedge clk); wake_req = 1'b0; end
            2: begin io_write(16'h93, 8'h00); io_write(16'h93, 8'h06); end
            3: begin cpu_shutdown = 1'b1; @(negedge clk); cpu_shutdown = 1'b0; end
            4: begin kbc_rst_req = 1'b1; @(negedge clk); kbc_rst_req = 1'b0; end
            5: io_write(16'h92, 8'h01);
            default: begin io_write(16'h93, 8'h00); io_write(16'h93, 8'h04); end
        endcase
    endtask

    task automatic measure(output int hw, output int sw);
        hw = 0; sw = 0;
        for (int g = 0; g < 200 && (hard_rst || init_rst); g++) begin
            hw += int'(hard_rst); sw += int'(init_rst);
            @(negedge clk);
        end
    endtask

    task automatic set_ids(input logic [IDW-1:0] p, input logic [IDW-1:0] a);
        id_wr = 1'b1; id_proc_wdata = p; id_arb_wdata = a;
        @(negedge clk);
        id_wr = 1'b0;
        exp_pid = p; exp_aid = a;
    endtask

    task automatic finish_run;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    initial begin
        int hw, sw, n;
        int unsigned seed;
        seed = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        // R1 / R8: power-on state
        chk(hard_rst == 1'b1, "R1 hard during pwr_good low", int'(hard_rst), 1);
        chk(init_rst == 1'b0, "R1 init during pwr_good low", int'(init_rst), 0);
        chk(rst_cause == 7'h01, "R8 cause after power-on", int'(rst_cause), 1);
        pwr_good = 1'b1;
        n = 0;
        for (int g = 0; g < 1000; g++) begin
            @(negedge clk);
            if (!hard_rst) break;
            n++;
        end
        chk(n == KHZ - 1, "R1 power-up hold length", n, KHZ - 1);

        // R3 / R7 shutdown keeps ids
        set_ids(4'h5, 4'hA);
        fire(3); measure(hw, sw);
        chk(sw == MINP && hw == 0, "R3 shutdown init width", sw, MINP);
        chk(rst_cause == 7'h08, "R8 shutdown cause", int'(rst_cause), 8);
        chk(proc_id == exp_pid && arb_id == exp_aid, "R7 ids kept by init", int'({proc_id, arb_id}), int'({exp_pid, exp_aid}));

        // R9 fast port readback
        fire(5);
        io_addr = 16'h92;
        #1 chk(io_rdata[0] == 1'b1 && init_rst, "R9 fast bit during init", int'(io_rdata), 1);
        measure(hw, sw);
        chk(sw == MINP - 0 && hw == 0, "R3 fast port init width", sw, MINP);
        chk(io_rdata == 8'h00, "R9 fast bit after init", int'(io_rdata), 0);
        chk(rst_cause == 7'h20, "R8 fast cause", int'(rst_cause), 32);

        // R4 no trigger cases
        io_write(16'h92, 8'h02);
        chk(init_rst == 1'b0 && hard_rst == 1'b0, "R4 fast write bit0 clear", int'(init_rst), 0);
        fire(6); measure(hw, sw);
        chk(sw == MINP && hw == 0, "R3 ctl soft init width", sw, MINP);
        chk(rst_cause == 7'h40, "R8 ctl soft cause", int'(rst_cause), 64);
        io_addr = 16'h93;
        #1 chk(io_rdata == 8'h04, "R10 ctl readback", int'(io_rdata), 4);
        io_write(16'h93, 8'h04);
        chk(init_rst == 1'b0 && hard_rst == 1'b0, "R4 ctl bit2 already set", int'(init_rst), 0);

        // R5 merge
        fire(4);
        repeat (5) @(negedge clk);
        cpu_shutdown = 1'b1; @(negedge clk); cpu_shutdown = 1'b0;
        measure(hw, sw);
        chk(sw == MINP - 6, "R5 merged pulse tail", sw, MINP - 6);
        chk(rst_cause == 7'h10, "R5 cause unchanged by merge", int'(rst_cause), 16);

        // R6 same-cycle priority
        wake_req = 1'b1; kbc_rst_req = 1'b1; @(negedge clk);
        wake_req = 1'b0; kbc_rst_req = 1'b0;
        measure(hw, sw);
        chk(hw == MINP && sw == 0, "R6 hard wins same cycle", sw, 0);
        chk(rst_cause == 7'h02, "R2 wake cause", int'(rst_cause), 2);
        chk(proc_id == 0 && arb_id == 0, "R7 ids cleared by hard", int'({proc_id, arb_id}), 0);
        exp_pid = '0; exp_aid = '0;

        // R6 wake preempts running init
        fire(3);
        repeat (3) @(negedge clk);
        wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;
        chk(hard_rst == 1'b1 && init_rst == 1'b0, "R6 hard preempts init", int'(init_rst), 0);
        measure(hw, sw);
        chk(hw == MINP && sw == 0, "R6 preempting hard width", hw, MINP);

        // R10 writes during hard ignored; R2 ctl hard
        set_ids(4'h3, 4'h7);
        fire(2);
        chk(hard_rst == 1'b1, "R2 ctl hard started", int'(hard_rst), 1);
        io_write(16'h93, 8'h04);
        set_ids(4'h9, 4'h9);
        exp_pid = '0; exp_aid = '0;
        measure(hw, sw);
        chk(hw == MINP - 2 && sw == 0, "R2 ctl hard width", hw, MINP - 2);
        io_addr = 16'h93;
        #1 chk(io_rdata == 8'h00, "R10 ctl cleared and write ignored", int'(io_rdata), 0);
        chk(proc_id == 0 && arb_id == 0, "R10 id write during hard ignored", int'({proc_id, arb_id}), 0);
        chk(rst_cause == 7'h04, "R8 ctl hard cause", int'(rst_cause), 4);

        // R11 simultaneous soft sources
        cpu_shutdown = 1'b1; kbc_rst_req = 1'b1; @(negedge clk);
        cpu_shutdown = 1'b0; kbc_rst_req = 1'b0;
        measure(hw, sw);
        chk(rst_cause == 7'h08 && sw == MINP, "R11 lowest index wins", int'(rst_cause), 8);

        // random rounds
        for (int r = 0; r < 60; r++) begin
            int src;
            src = 1 + int'($urandom % 6);
            set_ids(IDW'($urandom), IDW'($urandom));
            fire(src);
            measure(hw, sw);
            if (is_hard(src)) begin
                chk(hw == MINP && sw == 0, "R2 random hard width", hw, MINP);
                exp_pid = '0; exp_aid = '0;
            end else begin
                chk(sw == MINP && hw == 0, "R3 random init width", sw, MINP);
            end
            chk(int'(rst_cause) == exp_cause(src), "R8 random cause", int'(rst_cause), exp_cause(src));
            chk(proc_id == exp_pid && arb_id == exp_aid, "R7 random ids", int'({proc_id, arb_id}), int'({exp_pid, exp_aid}));
        end
        if (seed == 0) $display("seed zero");
        finish_run();
    end
endmodule